// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block controls sixty-four general-purpose pins organised as four banks of sixteen. Each bank holds its own direction, output-value and alternate-select settings, which drive the pad-control outputs directly. Every pin input passes through a two-flop synchroniser. A read-only register reports the synchronised level of each pin, whether or not the pin is an output.

Each pin can raise an interrupt. The pin can be edge triggered (rising or falling) or level triggered (high or low), and each pin has its own mask bit. A detected event sets a sticky bit in the bank's status register, and that bit stays set until software clears it with a write.

A summary word gathers one pending bit per bank together with six synchronised peripheral interrupt lines. A top control register enables individual summary sources and carries a global enable bit. The single host interrupt output is the OR of the enabled summary sources, gated by that global enable bit. A wake request is raised for any pending pin that is not excluded by its bank's sleep mask.

Register map, used by the software of the system:
- Bank registers sit at address bank*16 + index. The indices are:
  - 0: direction
  - 1: output
  - 2: alternate select
  - 3: pin level (read-only)
  - 4: mask
  - 5: sleep mask
  - 6: trigger type
  - 7: edge polarity
  - 8: level polarity
  - 9: status
- The summary word is at 0x40 and is read-only.
- The control register is at 0x41.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the following registers read 0: direction, output, alternate, trigger type, edge polarity, level polarity, status, summary and control. The mask and sleep-mask registers read 0xFFFF. irq_out and pad_oe are 0.
- R2: Bit i of bank b in the direction, output and alternate registers drives pad_oe, pad_out and pad_alt bit b*16+i. In the direction register, 1 means output.
- R3: The pin-level register (index 3) returns pad_in through two flops, regardless of direction. A pad change made before clock edge k is read back after edge k+1.
- R4: When the trigger-type bit is 1 (edge mode) and the edge-polarity bit is 1, a rising pad edge sets the status bit. The bit becomes readable after the third clock edge following the pad change. A falling edge sets nothing.
- R5: In edge mode, an edge-polarity bit of 0 detects falling edges only.
- R6: When the trigger-type bit is 0 (level mode), a level-polarity bit of 1 detects a high level and 0 detects a low level. A level that is still active sets the status bit again on the same edge that clears it.
- R7: A mask bit of 1 prevents the pin from setting its status bit.
- R8: A write to the status register ANDs the stored bits with the written data, so writing 0 clears the whole register. An event detected on the same edge as the write still sets its bit.
- R9: Summary bits 0 to 3 are the OR of the status registers of banks 0 to 3. Bits 4 to 9 are periph_irq[0] to [5] after two flops. Bits 10 to 15 read 0.
- R10: irq_out is 1 exactly when control bit 15 is 1 and at least one summary bit j (j from 0 to 9) is set together with control bit j.
- R11: wake_out is 1 exactly when some status bit is set whose sleep-mask bit is 0.
- R12: Unused addresses read 0, and writes to them have no effect. Writes to the pin-level register and to the summary word have no effect.
- R13: A polarity write takes effect from the clock edge after the one that stores it. A detection evaluated on the storing edge uses the old polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pad_in | input | 64 | Pin levels from the pads |
| pad_out | output | 64 | Output values for the pads |
| pad_oe | output | 64 | Output enables for the pads (1 = drive) |
| pad_alt | output | 64 | Alternate-function selects |
| periph_irq | input | 6 | Peripheral interrupt lines (active high) |
| irq_out | output | 1 | Interrupt request to the host |
| wake_out | output | 1 | Wake request |

## Verification
The status register can take a software clear and a fresh detection on the same clock edge. The bench provokes this by changing a pad exactly two edges before the clearing write, so that the detection lands on the write edge. The bench then expects the bit to survive, both for a new edge and for a level that is still active.

A polarity write can also coincide with the edge that would use the new polarity. The bench lines the two up and expects no event. It then moves the write one edge earlier and expects the event to be latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PINS        = 16;
    localparam int DATA_W      = 16;
    localparam int IDX_W       = 4;
    localparam int DEF_BANKS   = 4;
    localparam int DEF_PERIPH  = 6;
    localparam int GLOBAL_EN   = 15;

    typedef enum logic [IDX_W-1:0] {
        REG_DIR   = 4'd0,
        REG_OUT   = 4'd1,
        REG_ALT   = 4'd2,
        REG_PIN   = 4'd3,
        REG_MASK  = 4'd4,
        REG_SLEEP = 4'd5,
        REG_TRIG  = 4'd6,
        REG_EPOL  = 4'd7,
        REG_LPOL  = 4'd8,
        REG_STAT  = 4'd9
    } bank_reg_e;

    localparam logic [IDX_W-1:0] TOP_SUMMARY = 4'd0;
    localparam logic [IDX_W-1:0] TOP_CTRL    = 4'd1;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] out;
        logic [PINS-1:0] alt;
        logic [PINS-1:0] mask;
        logic [PINS-1:0] sleep;
        logic [PINS-1:0] trig;
        logic [PINS-1:0] epol;
        logic [PINS-1:0] lpol;
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '{
        dir:   '0,
        out:   '0,
        alt:   '0,
        mask:  '1,
        sleep: '1,
        trig:  '0,
        epol:  '0,
        lpol:  '0
    };

    // Per-pin raw detection (before masking)
    function automatic logic [PINS-1:0] pin_events(
        input logic [PINS-1:0] cur,
        input logic [PINS-1:0] prev,
        input logic [PINS-1:0] trig,
        input logic [PINS-1:0] epol,
        input logic [PINS-1:0] lpol
    );
        logic [PINS-1:0] rise;
        logic [PINS-1:0] fall;
        logic [PINS-1:0] edge_hit;
        logic [PINS-1:0] lvl_hit;
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        edge_hit = (epol & rise) | (~epol & fall);
        lvl_hit  = (lpol & cur) | (~lpol & ~cur);
        return (trig & edge_hit) | (~trig & lvl_hit);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [PINS-1:0]  wdata,
    input  logic [PINS-1:0]  pin_s,
    output logic [PINS-1:0]  rdata,
    output logic [PINS-1:0]  pad_dir,
    output logic [PINS-1:0]  pad_val,
    output logic [PINS-1:0]  pad_sel,
    output logic             pending,
    output logic             wake
);

    bank_cfg_t       cfg;
    logic [PINS-1:0] stat;
    logic [PINS-1:0] prev_s;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] stat_next;
    logic            stat_wr;

    assign stat_wr = wr_en && (bank_reg_e'(reg_idx) == REG_STAT);
    assign hit     = pin_events(pin_s, prev_s, cfg.trig, cfg.epol, cfg.lpol) & ~cfg.mask;

    // A detection on the clearing edge wins over the clear.
    always_comb begin
        stat_next = stat_wr ? (stat & wdata) : stat;
        stat_next = stat_next | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= CFG_RESET;
            stat   <= '0;
            prev_s <= '0;
        end else begin
            prev_s <= pin_s;
            stat   <= stat_next;
            if (wr_en) begin
                case (bank_reg_e'(reg_idx))
                    REG_DIR:   cfg.dir   <= wdata;
                    REG_OUT:   cfg.out   <= wdata;
                    REG_ALT:   cfg.alt   <= wdata;
                    REG_MASK:  cfg.mask  <= wdata;
                    REG_SLEEP: cfg.sleep <= wdata;
                    REG_TRIG:  cfg.trig  <= wdata;
                    REG_EPOL:  cfg.epol  <= wdata;
                    REG_LPOL:  cfg.lpol  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bank_reg_e'(reg_idx))
            REG_DIR:   rdata = cfg.dir;
            REG_OUT:   rdata = cfg.out;
            REG_ALT:   rdata = cfg.alt;
            REG_PIN:   rdata = pin_s;
            REG_MASK:  rdata = cfg.mask;
            REG_SLEEP: rdata = cfg.sleep;
            REG_TRIG:  rdata = cfg.trig;
            REG_EPOL:  rdata = cfg.epol;
            REG_LPOL:  rdata = cfg.lpol;
            REG_STAT:  rdata = stat;
            default:   rdata = '0;
        endcase
    end

    assign pad_dir = cfg.dir;
    assign pad_val = cfg.out;
    assign pad_sel = cfg.alt;
    assign pending = |stat;
    assign wake    = |(stat & ~cfg.sleep);

    AST_MASK_BLOCKS_SET: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & $past(cfg.mask)) == '0)); // R7

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((~stat & $past(stat)) != '0) |-> $past(stat_wr)); // R8

endmodule

// File: rtl/gpio_summary.sv
module gpio_summary
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int NUM_PERIPH = DEF_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_wr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_BANKS-1:0]  bank_pend,
    input  logic [NUM_PERIPH-1:0] periph_s,
    output logic [DATA_W-1:0]     summary,
    output logic [DATA_W-1:0]     ctrl,
    output logic                  irq
);

    localparam int SRC_N = NUM_BANKS + NUM_PERIPH;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= wdata;
        end
    end

    always_comb begin
        summary            = '0;
        summary[SRC_N-1:0] = {periph_s, bank_pend};
    end

    assign irq = ctrl[GLOBAL_EN] & (|(summary[SRC_N-1:0] & ctrl[SRC_N-1:0]));

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((bank_pend != '0) || (periph_s != '0))); // R10

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int NUM_PERIPH = DEF_PERIPH,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ADDR_W    = 1 + BANK_W + IDX_W,
    localparam int PAD_W     = NUM_BANKS * PINS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [PAD_W-1:0]      pad_in,
    output logic [PAD_W-1:0]      pad_out,
    output logic [PAD_W-1:0]      pad_oe,
    output logic [PAD_W-1:0]      pad_alt,
    input  logic [NUM_PERIPH-1:0] periph_irq,
    output logic                  irq_out,
    output logic                  wake_out
);

    logic                  top_region;
    logic                  top_ok;
    logic [BANK_W-1:0]     bank_sel;
    logic [IDX_W-1:0]      reg_idx;
    logic [PAD_W-1:0]      pad_s;
    logic [NUM_PERIPH-1:0] periph_s;
    logic [NUM_BANKS-1:0]  bank_pend;
    logic [NUM_BANKS-1:0]  bank_wake;
    logic [PINS-1:0]       bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0]     summary;
    logic [DATA_W-1:0]     ctrl;

    assign top_region = bus_addr[ADDR_W-1];
    assign bank_sel   = bus_addr[IDX_W +: BANK_W];
    assign reg_idx    = bus_addr[IDX_W-1:0];
    assign top_ok     = top_region && (bank_sel == '0);

    gpio_sync #(.WIDTH(PAD_W)) u_pad_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (pad_s)
    );

    gpio_sync #(.WIDTH(NUM_PERIPH)) u_periph_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (periph_irq),
        .q_sync  (periph_s)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr && !top_region && (bank_sel == BANK_W'(g));

        gpio_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_wr),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .pin_s   (pad_s[g*PINS +: PINS]),
            .rdata   (bank_rdata[g]),
            .pad_dir (pad_oe[g*PINS +: PINS]),
            .pad_val (pad_out[g*PINS +: PINS]),
            .pad_sel (pad_alt[g*PINS +: PINS]),
            .pending (bank_pend[g]),
            .wake    (bank_wake[g])
        );
    end

    gpio_summary #(
        .NUM_BANKS  (NUM_BANKS),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_summary (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (bus_wr && top_ok && (reg_idx == TOP_CTRL)),
        .wdata     (bus_wdata),
        .bank_pend (bank_pend),
        .periph_s  (periph_s),
        .summary   (summary),
        .ctrl      (ctrl),
        .irq       (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (!top_region) begin
            bus_rdata = bank_rdata[bank_sel];
        end else if (top_ok) begin
            if (reg_idx == TOP_SUMMARY)   bus_rdata = summary;
            else if (reg_idx == TOP_CTRL) bus_rdata = ctrl;
        end
    end

    assign wake_out = |bank_wake;

    AST_WAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> (bank_pend != '0)); // R11

    AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe != $past(pad_oe)) |-> $past(bus_wr && !top_region)); // R2

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out, pad_oe, pad_alt;
    logic [5:0]  periph_irq = '0;
    logic        irq_out, wake_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_alt(pad_alt),
        .periph_irq(periph_irq), .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [6:0] a, input logic [15:0] e);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic t_reset;
        expect_reg("R1 dir", 7'h00, 16'h0000);
        expect_reg("R1 mask", 7'h04, 16'hFFFF);
        expect_reg("R1 sleep", 7'h05, 16'hFFFF);
        expect_reg("R1 trig", 7'h36, 16'h0000);
        expect_reg("R1 stat", 7'h09, 16'h0000);
        expect_reg("R1 summary", 7'h40, 16'h0000);
        expect_reg("R1 ctrl", 7'h41, 16'h0000);
        check("R1 irq_out", irq_out, 0);
        check("R1 pad_oe", pad_oe, 64'h0);
    endtask

    task automatic t_drive;
        wr(7'h10, 16'hA5A5);
        wr(7'h11, 16'h1234);
        wr(7'h12, 16'h00FF);
        check("R2 pad_oe", pad_oe, 64'h0000_0000_A5A5_0000);
        check("R2 pad_out", pad_out, 64'h0000_0000_1234_0000);
        check("R2 pad_alt", pad_alt, 64'h0000_0000_00FF_0000);
        expect_reg("R2 dir readback", 7'h10, 16'hA5A5);
    endtask

    task automatic t_pin_level;
        wr(7'h20, 16'hFFFF);
        pad_in[47:32] = 16'hBEEF;
        tick(1);
        expect_reg("R3 level after one edge", 7'h23, 16'h0000);
        tick(1);
        expect_reg("R3 level after two edges", 7'h23, 16'hBEEF);
    endtask

    task automatic t_rise;
        wr(7'h06, 16'h0001);
        wr(7'h07, 16'h0001);
        wr(7'h04, 16'hFFFE);
        pad_in[0] = 1'b1;
        tick(2);
        expect_reg("R4 not yet latched", 7'h09, 16'h0000);
        tick(1);
        expect_reg("R4 rising latched", 7'h09, 16'h0001);
        wr(7'h09, 16'h0000);
        expect_reg("R8 clear by zero", 7'h09, 16'h0000);
        pad_in[0] = 1'b0;
        tick(5);
        expect_reg("R4 falling ignored", 7'h09, 16'h0000);
    endtask

    task automatic t_fall_and_clear;
        wr(7'h06, 16'h0003);
        wr(7'h04, 16'hFFFC);
        pad_in[1] = 1'b1;
        tick(5);
        expect_reg("R5 rising ignored", 7'h09, 16'h0000);
        pad_in[1] = 1'b0;
        tick(5);
        expect_reg("R5 falling latched", 7'h09, 16'h0002);
        pad_in[0] = 1'b1;
        tick(5);
        expect_reg("R8 two bits set", 7'h09, 16'h0003);
        wr(7'h09, 16'h0002);
        expect_reg("R8 AND write keeps ones", 7'h09, 16'h0002);
        wr(7'h09, 16'h0000);
        pad_in[0] = 1'b0;
        tick(5);
        pad_in[0] = 1'b1;
        tick(2);
        wr(7'h09, 16'h0000);
        expect_reg("R8 edge on clearing edge wins", 7'h09, 16'h0001);
        wr(7'h09, 16'h0000);
        expect_reg("R8 clear after race", 7'h09, 16'h0000);
        wr(7'h04, 16'hFFFF);
    endtask

    task automatic t_level;
        wr(7'h38, 16'h0010);
        wr(7'h34, 16'hFFEF);
        tick(3);
        expect_reg("R6 high mode, pin low", 7'h39, 16'h0000);
        pad_in[52] = 1'b1;
        tick(4);
        expect_reg("R6 high level latched", 7'h39, 16'h0010);
        wr(7'h39, 16'h0000);
        expect_reg("R6 held level re-sets", 7'h39, 16'h0010);
        pad_in[52] = 1'b0;
        tick(4);
        wr(7'h39, 16'h0000);
        expect_reg("R6 cleared after release", 7'h39, 16'h0000);
        wr(7'h38, 16'h0000);
        tick(2);
        expect_reg("R6 low level latched", 7'h39, 16'h0010);
        wr(7'h34, 16'hFFFF);
        wr(7'h39, 16'h0000);
        tick(3);
        expect_reg("R7 masked level stays clear", 7'h39, 16'h0000);
    endtask

    task automatic t_mask;
        wr(7'h26, 16'hFFFF);
        wr(7'h27, 16'hFFFF);
        pad_in[47:32] = 16'hFFFF;
        tick(5);
        expect_reg("R7 masked edges ignored", 7'h29, 16'h0000);
    endtask

    task automatic t_polarity;
        wr(7'h16, 16'h000C);
        wr(7'h14, 16'hFFF3);
        pad_in[18] = 1'b1;
        tick(2);
        wr(7'h17, 16'h0004);
        tick(3);
        expect_reg("R13 same-edge write uses old polarity", 7'h19, 16'h0000);
        pad_in[19] = 1'b1;
        tick(1);
        wr(7'h17, 16'h000C);
        tick(3);
        expect_reg("R13 earlier write applies", 7'h19, 16'h0008);
    endtask

    task automatic t_summary;
        periph_irq = 6'b100101;
        tick(3);
        expect_reg("R9 summary", 7'h40, 16'h0252);
    endtask

    task automatic t_irq;
        check("R10 irq off without global", irq_out, 0);
        wr(7'h41, 16'h8002);
        check("R10 bank1 enabled", irq_out, 1);
        wr(7'h41, 16'h0002);
        check("R10 global off", irq_out, 0);
        wr(7'h41, 16'h8001);
        check("R10 enabled source idle", irq_out, 0);
        wr(7'h41, 16'h8200);
        check("R10 peripheral 5 enabled", irq_out, 1);
    endtask

    task automatic t_wake;
        check("R11 excluded by sleep", wake_out, 0);
        wr(7'h15, 16'hFFF7);
        check("R11 wake source", wake_out, 1);
        wr(7'h19, 16'h0000);
        check("R11 wake drops on clear", wake_out, 0);
        expect_reg("R9 summary after clear", 7'h40, 16'h0250);
    endtask

    task automatic t_unmapped;
        expect_reg("R12 bank index 10", 7'h0A, 16'h0000);
        expect_reg("R12 top index 15", 7'h4F, 16'h0000);
        expect_reg("R12 top alias", 7'h52, 16'h0000);
        wr(7'h42, 16'hFFFF);
        expect_reg("R12 write unused", 7'h42, 16'h0000);
        wr(7'h40, 16'h0000);
        expect_reg("R12 summary write ignored", 7'h40, 16'h0250);
        wr(7'h23, 16'h0000);
        expect_reg("R12 pin level write ignored", 7'h23, 16'hFFFF);
        expect_reg("R12 ctrl untouched", 7'h41, 16'h8200);
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_drive();
        t_pin_level();
        t_rise();
        t_fall_and_clear();
        t_level();
        t_mask();
        t_polarity();
        t_summary();
        t_irq();
        t_wake();
        t_unmapped();
        finish_run();
    end

endmodule